// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Code Latch

This block is the parallel-mode digital front end of a 14-bit voltage-output converter. It holds two registers in series. The first captures a word from a 14-bit data bus under two active-low strobes, a select and a write. The second feeds the converter core and is filled from the first under an active-low load strobe. The analog side is not part of the block. The only result is the 14-bit two's complement code held in the second register.

All three strobes arrive asynchronously. Each passes through a two-flop synchronizer to a fast system clock, and the level-sensitive behaviour of the two stages is rebuilt with clocked registers. The two stages never follow their inputs in the same cycle. If the load strobe is tied low, a single write therefore becomes an output update as soon as the write ends. If the load strobe is pulsed, the update happens on its falling edge.

The block also raises a one-cycle pulse each time the output code changes. It keeps a flag that records whether the load strobe was high when the block came out of reset.

Top module: `dual_stage_code_latch`

## Requirements
- R1: During reset and right after it, both stages hold zero, `dacCode` is 0 and `updatePulse` is low.
- R2: The first stage tracks `busData` while both `selN` and `wrN` are low (after synchronization). It takes the last bus value seen before either strobe goes high. If only one of the two strobes is low, nothing is captured.
- R3: Once either `selN` or `wrN` is high, the first stage keeps its value no matter how `busData` changes.
- R4: While the first stage is tracking the bus, the second stage does not change, even with `loadN` low.
- R5: With `loadN` held low, the end of a write moves the new word to `dacCode` three clock edges after the releasing strobe edge: two synchronizer edges and one register edge.
- R6: A falling edge of `loadN` while the first stage is closed copies the first stage into `dacCode`.
- R7: While `loadN` is high, writes do not change `dacCode`.
- R8: `updatePulse` is high for exactly one cycle in the cycle in which `dacCode` takes a new value. It stays low if a transfer carries the same value.
- R9: `loadHighAtStart` is 1 when `loadN` was high during the first synchronized sample after reset, and 0 otherwise. After that sample it does not fall until the next reset.
- R10: The code passes through unchanged as 14-bit two's complement with bit 13 as the sign bit. The extremes 0x2000 (most negative), 0x1FFF (most positive), 0x3FFF (minus one) and 0 appear on `dacCode` exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| selN | input | 1 | Active-low chip select, asynchronous |
| wrN | input | 1 | Active-low write strobe, asynchronous |
| loadN | input | 1 | Active-low transfer strobe to the output stage, asynchronous |
| busData | input | 14 | Parallel data word, two's complement |
| dacCode | output | 14 | Code driving the converter core |
| updatePulse | output | 1 | One-cycle pulse when dacCode changes |
| loadHighAtStart | output | 1 | Load strobe was high at start-up |

## Verification
The properties assume that `busData` is stable from the moment both strobes are low until at least three clock cycles after a strobe is released. The bus is sampled directly, while the strobes arrive two cycles late through the synchronizers. They also assume that each strobe level lasts several clock cycles, so that no edge is lost in synchronization. The stimulus changes every input on the falling clock edge. It holds every strobe level for at least three cycles and keeps the bus steady across each write window and for four cycles after it. The only exception is a deliberate bus change placed inside an open write window.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic inOpen;     // first stage tracks the bus
    logic dacFollow;  // second stage tracks the first stage
  } latchCtl_t;

endpackage

// File: rtl/dlc_sync.sv
module dlc_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : gBit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], asyncIn[b]};
      end
      assign syncOut[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
  import dlc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selS,
  input  logic      wrS,
  input  logic      loadS,
  output latchCtl_t ctl,
  output logic      startFlag
);

  localparam int PRIME_W = $clog2(SYNC_STAGES + 2);
  localparam logic [PRIME_W-1:0] PRIME_AT  = PRIME_W'(SYNC_STAGES);
  localparam logic [PRIME_W-1:0] PRIME_END = PRIME_W'(SYNC_STAGES + 1);

  logic [PRIME_W-1:0] primeCnt;
  logic writeActive;

  // The write window is open only while both strobes are low; the
  // output stage is barred from following while it is open.
  always_comb begin
    writeActive   = ~selS & ~wrS;
    ctl.inOpen    = writeActive;
    ctl.dacFollow = ~loadS & ~writeActive;
  end

  // Sample the load strobe once the synchronizer holds real data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      primeCnt  <= '0;
      startFlag <= 1'b0;
    end else if (primeCnt != PRIME_END) begin
      primeCnt <= primeCnt + 1'b1;
      if (primeCnt == PRIME_AT) startFlag <= loadS;
    end
  end

endmodule

// File: rtl/dlc_datapath.sv
module dlc_datapath
  import dlc_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  latchCtl_t         ctl,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] dacCode,
  output logic              updatePulse
);

  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] dacReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg       <= '0;
      dacReg      <= '0;
      updatePulse <= 1'b0;
    end else begin
      if (ctl.inOpen)    inReg  <= busData;
      if (ctl.dacFollow) dacReg <= inReg;
      updatePulse <= ctl.dacFollow && (dacReg != inReg);
    end
  end

  assign dacCode = dacReg;

endmodule

// File: rtl/dual_stage_code_latch.sv
module dual_stage_code_latch
  import dlc_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              wrN,
  input  logic              loadN,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] dacCode,
  output logic              updatePulse,
  output logic              loadHighAtStart
);

  localparam int N_STROBES = 3;

  logic [N_STROBES-1:0] strobeRaw;
  logic [N_STROBES-1:0] strobeSync;
  latchCtl_t            ctl;

  assign strobeRaw = {loadN, wrN, selN};

  dlc_sync #(
    .WIDTH(N_STROBES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)
  ) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(strobeRaw), .syncOut(strobeSync)
  );

  dlc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .selS(strobeSync[0]), .wrS(strobeSync[1]), .loadS(strobeSync[2]),
    .ctl(ctl), .startFlag(loadHighAtStart)
  );

  dlc_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busData(busData),
    .dacCode(dacCode), .updatePulse(updatePulse)
  );

endmodule

// File: rtl/dlc_checker.sv
module dlc_checker
  import dlc_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input latchCtl_t         ctl,
  input logic [DATA_W-1:0] inCode,
  input logic [DATA_W-1:0] dacCode,
  input logic              updatePulse,
  input logic              startFlag
);

  AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.inOpen |=> $stable(inCode)); // R3

  AST_DAC_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inOpen |=> $stable(dacCode)); // R4

  AST_DAC_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dacFollow |=> dacCode == $past(inCode)); // R6

  AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    dacCode != $past(dacCode) |-> updatePulse); // R8

  AST_PULSE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |-> dacCode != $past(dacCode)); // R8

  AST_FLAG_NO_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(startFlag)); // R9

endmodule

bind dual_stage_code_latch dlc_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .inCode(uData.inReg),
  .dacCode(dacCode), .updatePulse(updatePulse), .startFlag(loadHighAtStart)
);

// File: tb/sim_dual_stage_code_latch.sv
module sim_dual_stage_code_latch;

  localparam int CLK_PERIOD = 10;
  localparam int W = 14;
  localparam int N_VEC = 9;
  // bit 14: 1 = load strobe held low during the write, 0 = pulsed afterwards
  localparam logic [14:0] VEC [N_VEC] = '{
    {1'b0, 14'h0123}, {1'b1, 14'h2000}, {1'b1, 14'h1FFF},
    {1'b0, 14'h3FFF}, {1'b0, 14'h3FFF}, {1'b1, 14'h0000},
    {1'b1, 14'h0000}, {1'b0, 14'h2AAA}, {1'b1, 14'h1555}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, wrN = 1'b1, loadN = 1'b1;
  logic [W-1:0] busData = '0;
  logic [W-1:0] dacCode;
  logic updatePulse, loadHighAtStart;

  int nRun = 0, nFail = 0, pulseCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rstN && updatePulse) pulseCnt++;

  dual_stage_code_latch u0 (
    .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .loadN(loadN),
    .busData(busData), .dacCode(dacCode), .updatePulse(updatePulse),
    .loadHighAtStart(loadHighAtStart)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic openWrite(input logic [W-1:0] d);
    busData = d; selN = 1'b0; wrN = 1'b0;
    cyc(4);
  endtask

  task automatic closeWrite(input logic [W-1:0] d);
    wrN = 1'b1; cyc(1); selN = 1'b1; cyc(4);
    busData = ~d;
  endtask

  task automatic pulseLoad();
    loadN = 1'b0; cyc(3); loadN = 1'b1; cyc(4);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [W-1:0] prev;
    cyc(3);
    check("R1 reset dac", int'(dacCode), 0);
    check("R1 reset pulse", int'(updatePulse), 0);
    rstN = 1'b1;
    cyc(6);
    check("R1 dac after reset", int'(dacCode), 0);
    check("R9 flag load high", int'(loadHighAtStart), 1);

    prev = '0;
    for (int i = 0; i < N_VEC; i++) begin
      logic [W-1:0] d;
      d = VEC[i][13:0];
      pulseCnt = 0;
      if (VEC[i][14]) begin
        loadN = 1'b0; cyc(4);
        openWrite(d);
        check("R4 inhibit during write", int'(dacCode), int'(prev));
        // release on this edge, then count edges (R5)
        wrN = 1'b1; cyc(2);
        check("R5 not yet updated", int'(dacCode), int'(prev));
        cyc(1);
        check("R5 update at write end", int'(dacCode), int'(d));
        selN = 1'b1; cyc(4); busData = ~d;
        loadN = 1'b1; cyc(4);
      end else begin
        openWrite(d);
        closeWrite(d);
        check("R7 no update with load high", int'(dacCode), int'(prev));
        pulseLoad();
        check("R6 load edge copies", int'(dacCode), int'(d));
      end
      check("R10 code passes", int'(dacCode), int'(d));
      check("R8 pulse count", pulseCnt, (d != prev) ? 1 : 0);
      prev = d;
    end

    // R2: last bus value in an open window wins; one strobe alone captures nothing
    openWrite(14'h0AAA);
    busData = 14'h0BBB; cyc(4);
    closeWrite(14'h0BBB);
    busData = 14'h0CCC; cyc(4);
    check("R3 held after release", int'(dacCode), int'(prev));
    pulseLoad();
    check("R2 last open value", int'(dacCode), 14'h0BBB);
    busData = 14'h0DDD; selN = 1'b0; cyc(5); selN = 1'b1; cyc(3);
    busData = 14'h0EEE; wrN = 1'b0; cyc(5); wrN = 1'b1; cyc(3);
    pulseLoad();
    check("R2 single strobe ignored", int'(dacCode), 14'h0BBB);

    // R1 and R9: second reset with load low
    rstN = 1'b0; loadN = 1'b0; cyc(3);
    check("R1 reset clears dac", int'(dacCode), 0);
    rstN = 1'b1; cyc(6);
    check("R9 flag load low", int'(loadHighAtStart), 0);
    check("R1 dac stays zero", int'(dacCode), 0);

    finish();
  end

endmodule